// File: doc/BRIEF.md
# Two-Stage Real-Time Clock Prescaler

This block turns a real-time clock input into two enable streams for a calendar. The first, pre-scaling stage divides the input clock by a programmable factor plus one and emits a one-cycle `pre_tick`. The second stage counts those pulses, divides them by its own factor plus one, and emits a one-cycle `step_tick`, which is the once-per-calendar-step enable. Both stages count down to zero, pulse, and reload. With the default factors of 127 and 255, a 32768 Hz input gives one `step_tick` per second.

Both factors sit in one 32-bit register. Software may change the register only while `init_mode` is high. It loads the register in two separate accesses: `wr_sel` picks which factor a write updates. A rejected write changes nothing and raises `wr_err` for one cycle. Writes are rejected when they arrive outside initialization mode, when they set the first-stage factor to zero, or when they set a reserved bit. While `init_mode` is high both counters are held at their factors and no pulses leave the block. When `init_mode` falls, both stages restart from the stored factors.

Top module: `rtc_tick_prescaler`

## Requirements
- R1: After reset, `rd_data` holds the first-stage factor A_RST (default 127) in bits 22:16 and the second-stage factor S_RST (default 255) in bits 14:0. All other bits read zero. `wr_err` is low.
- R2: While running, `pre_tick` is a one-cycle pulse that repeats every A+1 clock cycles, where A is the stored first-stage factor.
- R3: `step_tick` is high only in a cycle where `pre_tick` is high. It fires on every (S+1)th `pre_tick`, where S is the stored second-stage factor.
- R4: A write (`wr_en` high) while `init_mode` is low changes neither factor, and `wr_err` is high in the following cycle.
- R5: A write with `wr_sel`=1 whose bits 22:16 are zero is rejected: the first-stage factor is kept and `wr_err` pulses in the following cycle.
- R6: During initialization mode, an accepted write updates exactly one factor. `wr_sel`=1 loads bits 22:16 into the first-stage factor and `wr_sel`=0 loads bits 14:0 into the second-stage factor. The other factor is kept and `wr_err` stays low.
- R7: A write with any of bits 31:23 or bit 15 set is rejected: neither factor changes and `wr_err` pulses in the following cycle.
- R8: While `init_mode` is high, `pre_tick` and `step_tick` stay low.
- R9: After `init_mode` falls, counting restarts from the stored factors. Counting from and including the first clock edge that samples `init_mode` low, the first `pre_tick` follows edge A+1 and the first `step_tick` follows edge (A+1)(S+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Real-time clock input being divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_mode | input | 1 | High while the factors may be changed; counters are held |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 1 = first-stage factor, 0 = second-stage factor |
| wr_data | input | 32 | Write data in register layout |
| rd_data | output | 32 | Current register contents |
| wr_err | output | 1 | One-cycle pulse after a rejected write |
| pre_tick | output | 1 | First-stage enable pulse |
| step_tick | output | 1 | Second-stage enable pulse |

## Verification
The bench builds the prescaler with reset factors of 3 and 4 instead of 127 and 255. This lets the reset configuration produce several `step_tick` pulses within a few dozen cycles, so R1 and R9 can be checked without first rewriting the register. The field widths keep their defaults. As a result, the bench can also write the widest factors: a first stage of 127, and a second stage of 32767 behind a first stage of 1. This places both ends of each counter's range inside the run, along with a second-stage factor of zero.

// File: rtl/rtcps_pkg.sv
package rtcps_pkg;

   // Selects the factor targeted by a single register write access
   typedef enum logic {
      FLD_SYNC  = 1'b0,
      FLD_ASYNC = 1'b1
   } rtcps_fld_e;

endpackage

// File: rtl/rtcps_factor_reg.sv
module rtcps_factor_reg
   import rtcps_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int A_W   = 7,
   parameter int S_W   = 15,
   parameter int A_LSB = 16,
   parameter int S_LSB = 0,
   parameter int A_RST = 127,
   parameter int S_RST = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_mode,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [REG_W-1:0] wr_data,
   output logic [A_W-1:0]   fac_a,
   output logic [S_W-1:0]   fac_s,
   output logic [REG_W-1:0] rd_data,
   output logic             wr_err
);

   localparam int A_MSB = A_LSB + A_W - 1;
   localparam int S_MSB = S_LSB + S_W - 1;

   // Elaboration-time parameter checks
   if (A_RST == 0) begin : g_chk_rst_zero
      $error("first-stage reset factor must be nonzero");
   end
   if (A_RST >= (1 << A_W) || S_RST >= (1 << S_W)) begin : g_chk_rst_fit
      $error("reset factor does not fit its field");
   end
   if (A_MSB >= REG_W || S_MSB >= REG_W) begin : g_chk_fit
      $error("field lies outside the register");
   end
   if (!(A_LSB > S_MSB || S_LSB > A_MSB)) begin : g_chk_overlap
      $error("factor fields overlap");
   end

   logic [REG_W-1:0] resv_bits;
   logic [A_W-1:0]   a_field;
   logic [S_W-1:0]   s_field;
   logic             sel_async;
   logic             accept;

   // Per-bit decode: field bits read back the factors, all others are reserved
   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (i >= A_LSB && i <= A_MSB) begin : g_a
         assign rd_data[i]   = fac_a[i-A_LSB];
         assign resv_bits[i] = 1'b0;
      end else if (i >= S_LSB && i <= S_MSB) begin : g_s
         assign rd_data[i]   = fac_s[i-S_LSB];
         assign resv_bits[i] = 1'b0;
      end else begin : g_r
         assign rd_data[i]   = 1'b0;
         assign resv_bits[i] = wr_data[i];
      end
   end

   assign a_field   = wr_data[A_MSB:A_LSB];
   assign s_field   = wr_data[S_MSB:S_LSB];
   assign sel_async = (wr_sel == FLD_ASYNC);

   always_comb begin
      accept = wr_en && init_mode && (resv_bits == '0);
      if (sel_async && (a_field == '0)) begin
         accept = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fac_a  <= A_W'(A_RST);
         fac_s  <= S_W'(S_RST);
         wr_err <= 1'b0;
      end else begin
         if (accept && sel_async) begin
            fac_a <= a_field;
         end
         if (accept && !sel_async) begin
            fac_s <= s_field;
         end
         wr_err <= wr_en && !accept;
      end
   end

   // R4: a write outside initialization mode leaves the register alone and flags
   assert_locked_write_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !init_mode) |=> (wr_err && rd_data == $past(rd_data)));

   // R4: the error flag only ever follows a write
   assert_err_cause_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_err |-> $past(wr_en));

   // R5: the first-stage factor never holds zero
   assert_no_zero_a_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      fac_a != '0);

   // R7: a reserved-bit write leaves the register unchanged
   assert_resv_reject_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && resv_bits != '0) |=> (wr_err && $stable(rd_data)));

endmodule

// File: rtl/rtcps_countdown.sv
module rtcps_countdown #(
   parameter int W       = 7,
   parameter int RST_VAL = 127
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] reload_val,
   input  logic         load,
   input  logic         adv,
   output logic         pulse
);

   logic [W-1:0] cnt;
   logic         at_zero;

   assign at_zero = (cnt == '0);
   assign pulse   = adv && at_zero && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= W'(RST_VAL);
      end else if (load) begin
         cnt <= reload_val;
      end else if (adv) begin
         cnt <= at_zero ? reload_val : cnt - 1'b1;
      end
   end

   // R9: outside a load, the count never exceeds the factor it restarted from
   assert_cnt_bound_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !load |-> (cnt <= reload_val));

   // R8: a held counter produces no pulse
   assert_held_quiet_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !pulse);

endmodule

// File: rtl/rtc_tick_prescaler.sv
module rtc_tick_prescaler
   import rtcps_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int A_W   = 7,
   parameter int S_W   = 15,
   parameter int A_LSB = 16,
   parameter int S_LSB = 0,
   parameter int A_RST = 127,
   parameter int S_RST = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init_mode,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             wr_err,
   output logic             pre_tick,
   output logic             step_tick
);

   logic [A_W-1:0] fac_a;
   logic [S_W-1:0] fac_s;
   logic           init_q;
   logic           hold;

   rtcps_factor_reg #(
      .REG_W (REG_W),
      .A_W   (A_W),
      .S_W   (S_W),
      .A_LSB (A_LSB),
      .S_LSB (S_LSB),
      .A_RST (A_RST),
      .S_RST (S_RST)
   ) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_mode (init_mode),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .fac_a     (fac_a),
      .fac_s     (fac_s),
      .rd_data   (rd_data),
      .wr_err    (wr_err)
   );

   // One extra hold cycle after init ends so a last-cycle write is picked up
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q <= 1'b0;
      end else begin
         init_q <= init_mode;
      end
   end

   assign hold = init_mode || init_q;

   rtcps_countdown #(
      .W       (A_W),
      .RST_VAL (A_RST)
   ) u_stage_a (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload_val (fac_a),
      .load       (hold),
      .adv        (1'b1),
      .pulse      (pre_tick)
   );

   rtcps_countdown #(
      .W       (S_W),
      .RST_VAL (S_RST)
   ) u_stage_s (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload_val (fac_s),
      .load       (hold),
      .adv        (pre_tick),
      .pulse      (step_tick)
   );

   // R3: the output tick only coincides with a first-stage tick
   assert_step_on_pre_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      step_tick |-> pre_tick);

   // R2: first-stage tick lasts a single cycle (factor is never zero)
   assert_pre_single_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      pre_tick |=> !pre_tick);

   // R8: nothing leaves the block during initialization mode
   assert_quiet_init_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      init_mode |-> (!pre_tick && !step_tick));

endmodule

// File: tb/tb_rtc_tick_prescaler.sv
module tb_rtc_tick_prescaler;
   import rtcps_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        init_mode;
   logic        wr_en;
   logic        wr_sel;
   logic [31:0] wr_data;
   logic [31:0] rd_data;
   logic        wr_err;
   logic        pre_tick;
   logic        step_tick;

   always #5 clk = ~clk;

   rtc_tick_prescaler #(
      .A_RST (3),
      .S_RST (4)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_mode (init_mode),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .rd_data   (rd_data),
      .wr_err    (wr_err),
      .pre_tick  (pre_tick),
      .step_tick (step_tick)
   );

   int vectors     = 0;
   int miscompares = 0;
   int cyc         = 0;
   int exp_q[$];
   bit mon_on    = 1'b0;
   bit quiet_chk = 1'b0;
   int c0 = 0;
   int ea = 1;
   int es = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic logic [31:0] word(input int a, input int s);
      logic [6:0]  af = a[6:0];
      logic [14:0] sf = s[14:0];
      return {9'b0, af, 1'b0, sf};
   endfunction

   // Monitor: compares outputs against the scoreboard every cycle
   always @(negedge clk) begin
      int ph;
      int e;
      if (mon_on) begin
         ph = (cyc - c0) % (ea + 1);
         chk(pre_tick == (ph == ea), "R2 pre_tick", pre_tick, (ph == ea));
         if (step_tick) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3 unexpected step_tick", cyc, -1);
            end else begin
               e = exp_q.pop_front();
               chk(e == cyc, "R3/R9 step_tick cycle", cyc, e);
            end
         end
      end
      if (quiet_chk) begin
         chk(!pre_tick && !step_tick, "R8 ticks in init", {pre_tick, step_tick}, 0);
      end
   end

   task automatic wr(input logic sel, input logic [31:0] d, input bit exp_err, input string req);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_sel  = sel;
      wr_data = d;
      @(negedge clk);
      wr_en   = 1'b0;
      wr_data = '0;
      chk(wr_err == exp_err, req, wr_err, exp_err);
   endtask

   task automatic chk_reg(input logic [31:0] exp, input string req);
      chk(rd_data == exp, req, rd_data, exp);
   endtask

   // Driver: leaves init, pushes expected step_tick cycles, re-enters init
   task automatic run(input int a, input int s, input int n);
      int p;
      int last;
      @(negedge clk);
      quiet_chk = 1'b0;
      init_mode = 1'b0;
      c0 = cyc + 1;
      ea = a;
      es = s;
      p  = (a + 1) * (s + 1);
      for (int k = 0; k < n; k++) exp_q.push_back(c0 + k * p + p - 1);
      last = c0 + n * p - 1;
      #1 mon_on = 1'b1;
      while (cyc < last + 1) @(negedge clk);
      mon_on = 1'b0;
      chk(exp_q.size() == 0, "R3 missing step_tick", exp_q.size(), 0);
      exp_q.delete();
      @(negedge clk);
      init_mode = 1'b1;
      #1 quiet_chk = 1'b1;
   endtask

   task automatic finish_up();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      finish_up();
   end

   initial begin
      rst_n     = 1'b0;
      init_mode = 1'b1;
      wr_en     = 1'b0;
      wr_sel    = FLD_SYNC;
      wr_data   = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 quiet_chk = 1'b1;
      @(negedge clk);
      chk_reg(word(3, 4), "R1 reset register");
      chk(wr_err == 1'b0, "R1 reset wr_err", wr_err, 0);
      repeat (10) @(negedge clk);

      // Reset factors: A=3, S=4
      run(3, 4, 3);

      // R4: writes while running are ignored
      @(negedge clk);
      quiet_chk = 1'b0;
      init_mode = 1'b0;
      wr(FLD_ASYNC, word(9, 0), 1'b1, "R4 async write outside init");
      chk_reg(word(3, 4), "R4 register after async write");
      wr(FLD_SYNC, word(0, 9), 1'b1, "R4 sync write outside init");
      chk_reg(word(3, 4), "R4 register after sync write");
      @(negedge clk);
      init_mode = 1'b1;
      #1 quiet_chk = 1'b1;

      // R5: zero first-stage factor rejected
      wr(FLD_ASYNC, word(0, 6), 1'b1, "R5 zero factor err");
      chk_reg(word(3, 4), "R5 register kept");

      // R7: reserved bits rejected
      wr(FLD_SYNC, word(0, 2) | 32'h0000_8000, 1'b1, "R7 bit15 err");
      wr(FLD_ASYNC, word(1, 0) | 32'h8000_0000, 1'b1, "R7 bit31 err");
      wr(FLD_ASYNC, word(1, 0) | 32'h0080_0000, 1'b1, "R7 bit23 err");
      chk_reg(word(3, 4), "R7 register kept");

      // R6: each write updates only its own field
      wr(FLD_SYNC, word(5, 2), 1'b0, "R6 sync write ok");
      chk_reg(word(3, 2), "R6 first-stage kept");
      wr(FLD_ASYNC, word(1, 7), 1'b0, "R6 async write ok");
      chk_reg(word(1, 2), "R6 second-stage kept");
      run(1, 2, 4);

      // Second-stage factor zero
      wr(FLD_SYNC, word(0, 0), 1'b0, "R6 sync zero ok");
      wr(FLD_ASYNC, word(6, 0), 1'b0, "R6 async six ok");
      chk_reg(word(6, 0), "R6 register");
      run(6, 0, 3);

      // Widest first stage
      wr(FLD_ASYNC, word(127, 0), 1'b0, "R6 async max ok");
      wr(FLD_SYNC, word(0, 1), 1'b0, "R6 sync one ok");
      chk_reg(word(127, 1), "R6 register");
      run(127, 1, 2);

      // Widest second stage
      wr(FLD_ASYNC, word(1, 0), 1'b0, "R6 async one ok");
      wr(FLD_SYNC, word(0, 32767), 1'b0, "R6 sync max ok");
      chk_reg(word(1, 32767), "R6 register");
      run(1, 32767, 1);

      repeat (5) @(negedge clk);
      finish_up();
   end

endmodule